// File: doc/BRIEF.md
# Bit Clock and Frame Sync Generator

This block derives a serial audio bit clock and a periodic frame-sync waveform from a fast input clock, for the transmit and receive shifters of a serial audio port. One configuration word sets the clock divisor, the frame length and the frame-sync pulse length, all counted in bit clocks. Two more bits in the same word choose whether frame sync is generated at all and whether the divider counts the core clock or rising edges of an external clock pin. Alongside the bit clock, the block drives single-cycle strobes for the shifters. The launch strobe marks where data changes. The sample strobe marks where data is captured. A start-of-frame strobe marks bit zero of each frame.

The divider and the frame-sync output have separate enables. Frame sync can only start once the divider is running. A polarity input inverts the frame-sync level. With that inversion, the same timing gives either a short DSP-style pulse or a 50% word-select waveform in which the first half of the frame is low. The configuration is sampled freely while no frame is running. Once frames are running, it is captured only at a frame boundary, so a new setting never cuts a frame short.

Top module: `audio_clk_fs_gen`

## Requirements
- R1: After reset, bitClk, txEdge, rxEdge and frameStart are 0, and frameSync sits at its inactive level, which equals fsActiveLow.
- R2: The divisor field is cfgWord[7:0] and holds the divisor minus one. With the internal clock selected, txEdge pulses exactly once every (field+1) clock cycles.
- R3: rxEdge pulses (field>>1)+1 cycles after each txEdge. bitClk falls one cycle after txEdge and rises one cycle after rxEdge, so it is high for field-(field>>1) cycles of each bit.
- R4: The frame length field is cfgWord[27:16] and holds the length in bit clocks minus one. frameStart pulses once every (period+1)*(divisor) cycles.
- R5: The pulse-length field is cfgWord[15:8] and holds the active length in bit clocks minus one. frameSync is active for (pulse+1) bit clocks from the start of each frame.
- R6: With the pulse field set to 15 and the period field set to 31, frameSync is active for exactly half of each frame.
- R7: fsActiveLow=1 inverts frameSync. The line idles high and is low during the active part of the frame.
- R8: When cfgWord[28] is 0, no frameStart is produced and frameSync stays at its inactive level, even with both enables set.
- R9: With genEnable at 0, fsEnable has no effect: neither txEdge nor frameStart pulses.
- R10: When cfgWord[29] is 0, the divider counts rising edges of extClkIn, so txEdge spacing is (field+1) external periods. With extClkIn held still, txEdge does not pulse.
- R11: A configuration change written while a frame runs takes effect only at the next frame boundary. The current frame keeps its old length and the next frame uses the new one.
- R12: frameStart is a one-cycle pulse that coincides with the cycle in which frameSync turns active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 30 | Divisor [7:0], pulse [15:8], period [27:16], frame-sync mode [28], internal clock select [29] |
| genEnable | input | 1 | Runs the clock divider |
| fsEnable | input | 1 | Allows frame-sync generation once the divider runs |
| fsActiveLow | input | 1 | Inverts the frame-sync level |
| extClkIn | input | 1 | External clock pin, synchronized internally |
| bitClk | output | 1 | Divided bit clock |
| frameSync | output | 1 | Frame-sync waveform |
| frameStart | output | 1 | One-cycle pulse at bit zero of each frame |
| txEdge | output | 1 | One-cycle launch strobe (bit clock falling edge) |
| rxEdge | output | 1 | One-cycle sample strobe (bit clock rising edge) |

## Verification
Odd and even divisors (3 and 6) separate an off-by-one in the divider compare from an error in the half-period sample point. Short DSP-style pulses and the 16-of-32 symmetric setting are both used. Together they show whether the pulse and period counts are decoded independently and whether the active window ends on the right bit. The external-clock runs, with a toggling pin and with a still pin, show that the internal clock is truly deselected. A mid-frame period change shows whether new settings are applied early, and the two frame lengths on either side of the boundary are compared.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int DIV_W   = 8;
  localparam int PW_W    = 8;
  localparam int PER_W   = 12;
  localparam int DIV_LSB = 0;
  localparam int PW_LSB  = DIV_LSB + DIV_W;
  localparam int PER_LSB = PW_LSB + PW_W;
  localparam int MODE_BIT = PER_LSB + PER_W;
  localparam int CLK_BIT = MODE_BIT + 1;
  localparam int CFG_W   = CLK_BIT + 1;

  typedef struct packed {
    logic [PER_W-1:0] period;
    logic [PW_W-1:0]  pulse;
    logic [DIV_W-1:0] div;
    logic             fsMode;
    logic             intClk;
  } srg_cfg_t;

  typedef struct packed {
    logic launch;
    logic sample;
    logic arm;
  } srg_strobe_t;

  function automatic srg_cfg_t decodeCfg(input logic [CFG_W-1:0] w);
    srg_cfg_t c;
    c.div    = w[DIV_LSB +: DIV_W];
    c.pulse  = w[PW_LSB +: PW_W];
    c.period = w[PER_LSB +: PER_W];
    c.fsMode = w[MODE_BIT];
    c.intClk = w[CLK_BIT];
    return c;
  endfunction
endpackage

// File: rtl/srg_ctrl.sv
module srg_ctrl
  import srg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             genEnable,
  input  logic             fsEnable,
  input  logic             extClkIn,
  input  logic             frameWrap,
  input  logic             fsActive,
  output srg_strobe_t      strobes,
  output srg_cfg_t         cfgLive
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0]  extSync;
  logic             extRise;
  logic             tick;
  logic [DIV_W-1:0] divCnt;
  logic             armQ;
  logic             atEnd;

  always_ff @(posedge clk) begin
    if (!rstN) extSync <= '0;
    else       extSync <= {extSync[SH_W-2:0], extClkIn};
  end
  assign extRise = extSync[SH_W-2] & ~extSync[SH_W-1];
  assign tick    = cfgLive.intClk ? 1'b1 : extRise;
  assign atEnd   = (divCnt >= cfgLive.div);

  always_ff @(posedge clk) begin
    if (!rstN || !genEnable) divCnt <= '0;
    else if (tick)           divCnt <= atEnd ? '0 : divCnt + {{(DIV_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     cfgLive <= decodeCfg('0);
    else if (!fsActive || frameWrap) cfgLive <= decodeCfg(cfgWord);
  end

  always_ff @(posedge clk) begin
    if (!rstN) armQ <= 1'b0;
    else       armQ <= genEnable && fsEnable && cfgLive.fsMode;
  end

  assign strobes.launch = genEnable && tick && atEnd;
  assign strobes.sample = genEnable && tick && (divCnt == (cfgLive.div >> 1));
  assign strobes.arm    = armQ;

  assert_arm_needs_gen_R9: assert property (@(posedge clk) disable iff (!rstN)
    armQ |-> $past(genEnable));
  assert_launch_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.launch && cfgLive.div != '0) |=> (!strobes.launch || cfgLive.div == '0));
  assert_edges_apart_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.launch && strobes.sample) |-> (cfgLive.div <= 8'd1));
  assert_ext_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLive.intClk && $stable(extSync)) |-> !strobes.launch);
endmodule

// File: rtl/srg_datapath.sv
module srg_datapath
  import srg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  srg_strobe_t strobes,
  input  srg_cfg_t    cfgLive,
  input  logic        fsActiveLow,
  output logic        bitClk,
  output logic        frameSync,
  output logic        frameStart,
  output logic        fsActive,
  output logic        frameWrap
);
  logic [PER_W-1:0] bitCnt;
  logic             lastBit;
  logic             inPulse;

  assign lastBit   = (bitCnt >= cfgLive.period);
  assign frameWrap = fsActive && strobes.launch && lastBit;
  assign inPulse   = fsActive && (bitCnt <= {{(PER_W-PW_W){1'b0}}, cfgLive.pulse});
  assign frameSync = inPulse ^ fsActiveLow;

  always_ff @(posedge clk) begin
    if (!rstN)                  bitClk <= 1'b0;
    else if (strobes.launch)    bitClk <= 1'b0;
    else if (strobes.sample)    bitClk <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !strobes.arm) begin
      fsActive   <= 1'b0;
      bitCnt     <= '0;
      frameStart <= 1'b0;
    end else begin
      frameStart <= strobes.launch && (!fsActive || lastBit);
      if (strobes.launch) begin
        fsActive <= 1'b1;
        if (!fsActive || lastBit) bitCnt <= '0;
        else                      bitCnt <= bitCnt + {{(PER_W-1){1'b0}}, 1'b1};
      end
    end
  end

  assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && (cfgLive.period != '0 || cfgLive.div != '0)) |=> !frameStart);
  assert_start_on_launch_R11: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> $past(strobes.launch));
  assert_start_sync_active_R12: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (frameSync != fsActiveLow));
  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.arm |=> (frameSync == fsActiveLow) || !$stable(fsActiveLow));
endmodule

// File: rtl/audio_clk_fs_gen.sv
module audio_clk_fs_gen
  import srg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             genEnable,
  input  logic             fsEnable,
  input  logic             fsActiveLow,
  input  logic             extClkIn,
  output logic             bitClk,
  output logic             frameSync,
  output logic             frameStart,
  output logic             txEdge,
  output logic             rxEdge
);
  srg_strobe_t strobes;
  srg_cfg_t    cfgLive;
  logic        frameWrap;
  logic        fsActive;

  srg_ctrl #(.SYNC_STAGES(2)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .genEnable(genEnable),
    .fsEnable(fsEnable), .extClkIn(extClkIn), .frameWrap(frameWrap),
    .fsActive(fsActive), .strobes(strobes), .cfgLive(cfgLive)
  );

  srg_datapath uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgLive(cfgLive),
    .fsActiveLow(fsActiveLow), .bitClk(bitClk), .frameSync(frameSync),
    .frameStart(frameStart), .fsActive(fsActive), .frameWrap(frameWrap)
  );

  assign txEdge = strobes.launch;
  assign rxEdge = strobes.sample;
endmodule

// File: tb/tb_audio_clk_fs_gen.sv
module tb_audio_clk_fs_gen;
  logic clk = 0;
  logic rstN = 0;
  logic [29:0] cfgWord = '0;
  logic genEnable = 0, fsEnable = 0, fsActiveLow = 0, extClkIn = 0;
  logic bitClk, frameSync, frameStart, txEdge, rxEdge;
  logic extRun = 0;
  int extCnt = 0;
  int nChecks = 0, nFail = 0, cycles = 0;

  always #2.5 clk = ~clk;

  audio_clk_fs_gen dut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .genEnable(genEnable),
    .fsEnable(fsEnable), .fsActiveLow(fsActiveLow), .extClkIn(extClkIn),
    .bitClk(bitClk), .frameSync(frameSync), .frameStart(frameStart),
    .txEdge(txEdge), .rxEdge(rxEdge)
  );

  always @(negedge clk) begin
    if (extRun) begin
      extCnt++;
      if (extCnt == 4) begin extCnt = 0; extClkIn = ~extClkIn; end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  function automatic logic [29:0] mkCfg(int d, int w, int p, bit mode, bit intc);
    return {intc, mode, 12'(p), 8'(w), 8'(d)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitSig(int sel, int limit, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk); cyc++;
      if (cyc > limit) begin cyc = -1; return; end
    end while (!((sel == 0 && txEdge) || (sel == 1 && frameStart) || (sel == 2 && rxEdge)));
  endtask

  task automatic setup(logic [29:0] c, bit fs, bit pol);
    @(negedge clk);
    genEnable = 0; fsEnable = 0; cfgWord = c; fsActiveLow = pol;
    repeat (3) @(negedge clk);
    genEnable = 1; fsEnable = fs;
  endtask

  task automatic tReset();
    @(negedge clk);
    check(bitClk == 0 && txEdge == 0 && rxEdge == 0 && frameStart == 0, "R1 strobes",
          {bitClk, txEdge, rxEdge, frameStart}, 0);
    check(frameSync == 0, "R1 frameSync idle", frameSync, 0);
  endtask

  task automatic tDivider(int d);
    int c;
    setup(mkCfg(d, 0, 0, 0, 1), 0, 0);
    waitSig(0, 500, c);
    waitSig(0, 500, c);
    check(c == d + 1, "R2 txEdge spacing", c, d + 1);
  endtask

  task automatic tEdges(int d);
    int c, hi;
    setup(mkCfg(d, 0, 0, 0, 1), 0, 0);
    waitSig(0, 500, c);
    waitSig(2, 500, c);
    check(c == (d >> 1) + 1, "R3 rxEdge offset", c, (d >> 1) + 1);
    waitSig(0, 500, c);
    hi = 0;
    for (int i = 0; i < d + 1; i++) begin
      @(negedge clk);
      if (i == 0) check(bitClk == 0, "R3 bitClk low after txEdge", bitClk, 0);
      if (bitClk) hi++;
    end
    check(hi == d - (d >> 1), "R3 bitClk high cycles", hi, d - (d >> 1));
  endtask

  task automatic measureFrame(int d, int w, int p, bit pol, string rq, string rw);
    int c, act, n;
    n = (p + 1) * (d + 1);
    waitSig(1, 20000, c);
    act = 0;
    for (int i = 0; i < n; i++) begin
      if (frameSync != pol) act++;
      @(negedge clk);
    end
    check(frameStart == 1, rq, frameStart, 1);
    check(act == (w + 1) * (d + 1), rw, act, (w + 1) * (d + 1));
  endtask

  task automatic tFrame();
    int c;
    setup(mkCfg(3, 2, 7, 1, 1), 1, 0);
    waitSig(1, 2000, c);
    waitSig(1, 2000, c);
    check(c == 32, "R4 frame spacing", c, 32);
    measureFrame(3, 2, 7, 0, "R4 next frame start", "R5 pulse length");
    @(negedge clk);
    check(frameStart == 0, "R12 one-cycle start", frameStart, 0);
  endtask

  task automatic tSymmetric();
    setup(mkCfg(1, 15, 31, 1, 1), 1, 0);
    measureFrame(1, 15, 31, 0, "R6 frame boundary", "R6 half duty");
  endtask

  task automatic tPolarity();
    int c;
    setup(mkCfg(1, 1, 5, 1, 1), 0, 1);
    repeat (2) @(negedge clk);
    check(frameSync == 1, "R7 idle high", frameSync, 1);
    fsEnable = 1;
    waitSig(1, 2000, c);
    check(frameSync == 0, "R7 active low at start", frameSync, 0);
    measureFrame(1, 1, 5, 1, "R7 frame boundary", "R7 low length");
  endtask

  task automatic tNoMode();
    int c, lvl;
    setup(mkCfg(1, 1, 5, 0, 1), 1, 0);
    lvl = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (frameSync) lvl++;
    end
    waitSig(1, 100, c);
    check(c == -1, "R8 no frameStart", c, -1);
    check(lvl == 0, "R8 frameSync inactive", lvl, 0);
  endtask

  task automatic tNoGen();
    int c;
    @(negedge clk);
    genEnable = 0; fsEnable = 1; cfgWord = mkCfg(1, 1, 5, 1, 1);
    waitSig(0, 100, c);
    check(c == -1, "R9 no txEdge", c, -1);
    waitSig(1, 100, c);
    check(c == -1, "R9 no frameStart", c, -1);
  endtask

  task automatic tExt();
    int c;
    setup(mkCfg(2, 0, 0, 0, 0), 0, 0);
    waitSig(0, 200, c);
    check(c == -1, "R10 still pin", c, -1);
    extCnt = 0; extRun = 1;
    waitSig(0, 500, c);
    waitSig(0, 500, c);
    check(c == 24, "R10 external spacing", c, 24);
    extRun = 0;
  endtask

  task automatic tReload();
    int c;
    setup(mkCfg(1, 1, 7, 1, 1), 1, 0);
    waitSig(1, 2000, c);
    waitSig(1, 2000, c);
    repeat (3) @(negedge clk);
    cfgWord = mkCfg(1, 1, 11, 1, 1);
    waitSig(1, 2000, c);
    check(c == 13, "R11 current frame rest", c, 13);
    waitSig(1, 2000, c);
    check(c == 24, "R11 new frame length", c, 24);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    rstN = 1;
    tDivider(3);
    tDivider(6);
    tEdges(6);
    tEdges(3);
    tFrame();
    tSymmetric();
    tPolarity();
    tNoMode();
    tNoGen();
    tExt();
    tReload();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule